// File: doc/BRIEF.md
# Parallel Port Test-Mode FIFO

This block is the host-facing side of a parallel port's test mode. A 16-byte FIFO sits behind one data register: the host pushes bytes by writing that register and pops them by reading it. Overflow and underflow never stall the host. A byte written while the FIFO is full is dropped. A read while the FIFO is empty returns the last byte that was really popped.

A service flag tells the host when to act, and a direction bit in a small control register sets what the flag means. With the direction bit at 0 the FIFO is treated as an outbound buffer, and the flag rises when enough space is free. With the direction bit at 1 it is treated as an inbound buffer, and the flag rises when enough bytes are stored. Two fixed registers let software identify the implementation. One reports the word size. The other shows that compression is not supported and mirrors the live level of the interrupt request line. All register reads are combinational from the select lines. Writes and pops take effect on the rising clock edge.

Top module: `ppTestFifo`

## Requirements
- R1: A synchronous active-high reset leaves the FIFO empty (fifoEmpty 1, fifoFull 0), the direction bit 0 and the last-read byte 00h.
- R2: A write to the data register (select 00) while the FIFO is full is dropped: the occupancy and the stored bytes are unchanged.
- R3: A read of the data register while the FIFO is empty returns the most recently popped byte and does not change the occupancy.
- R4: fifoFull is 1 exactly when 16 bytes are stored, and fifoEmpty is 1 exactly when none are stored, in every cycle.
- R5: Bytes leave the data register in the order they were written, whatever the value of the direction bit. While the FIFO is not empty, the data register shows the oldest byte.
- R6: With the direction bit 0, serviceIntr is 1 exactly when the free space (16 minus the occupancy) is at least the write threshold (default 4).
- R7: With the direction bit 1, serviceIntr is 1 exactly when the occupancy is at least the read threshold (default 12).
- R8: Select 01 always reads 10h, which signals an 8-bit word, and writes to it have no effect.
- R9: Select 10 reads bit 7 as 0 (no compression), bit 6 as the current irqLevel input, and all other bits as 0.
- R10: A write to select 11 loads the direction bit from wrData bit 0, and a read of select 11 returns the direction bit in bit 0 with the other bits 0.
- R11: A cycle with both wrEn and rdEn on the data register pops if the FIFO was not empty and pushes if it was not full, judged at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| regSel | input | 2 | Register select: 00 data, 01 config A, 10 config B, 11 control |
| wrEn | input | 1 | Write strobe for the selected register |
| rdEn | input | 1 | Read strobe; pops the FIFO when the data register is selected |
| wrData | input | 8 | Write data |
| irqLevel | input | 1 | Live level of the interrupt request line |
| rdData | output | 8 | Read data of the selected register (combinational) |
| fifoFull | output | 1 | FIFO holds 16 bytes |
| fifoEmpty | output | 1 | FIFO holds no bytes |
| serviceIntr | output | 1 | Threshold reached, with a meaning set by the direction bit |

## Verification
Faults in the pointers or the occupancy counter show up at the ports within a few cycles. A slipped read pointer returns the wrong head byte on the next data-register read. A miscounted occupancy moves fifoFull, fifoEmpty or serviceIntr off the reference one cycle after the offending push or pop. A corrupted last-read register only becomes visible on the next read of an empty FIFO, so the bench deliberately reads past empty after each drain. The reference model is compared in every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/ppFifoPkg.sv
package ppFifoPkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_CFGA = 2'b01,
    SEL_CFGB = 2'b10,
    SEL_CTRL = 2'b11
  } regSel_e;

  // Strobes issued by the control to the storage datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

endpackage

// File: rtl/ppFifoCtrl.sv
module ppFifoCtrl
  import ppFifoPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WR_THRESH = 4,
  parameter int RD_THRESH = 12,
  parameter int PTR_W     = $clog2(DEPTH),
  parameter int CNT_W     = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             dirIn,
  output fifoStrobe_t      strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] occ,
  output logic             dirBit,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic             serviceIntr
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WR_TH_C = CNT_W'(WR_THRESH);
  localparam logic [CNT_W-1:0] RD_TH_C = CNT_W'(RD_THRESH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic             isData;
  logic             dirLoad;
  logic [CNT_W-1:0] freeCnt;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    isData      = (regSel == SEL_DATA);
    fifoFull    = (occ == DEPTH_C);
    fifoEmpty   = (occ == '0);
    strobe.push = isData && wrEn && !fifoFull;
    strobe.pop  = isData && rdEn && !fifoEmpty;
    dirLoad     = (regSel == SEL_CTRL) && wrEn;
    freeCnt     = DEPTH_C - occ;
    serviceIntr = dirBit ? (occ >= RD_TH_C) : (freeCnt >= WR_TH_C);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      occ    <= '0;
      dirBit <= 1'b0;
    end else begin
      if (strobe.push) wrPtr <= bumpPtr(wrPtr);
      if (strobe.pop)  rdPtr <= bumpPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      if (dirLoad) dirBit <= dirIn;
    end
  end

endmodule

// File: rtl/ppFifoData.sv
module ppFifoData
  import ppFifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  fifoStrobe_t      strobe,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       regSel,
  input  logic             fifoEmpty,
  input  logic             dirBit,
  input  logic             irqLevel,
  output logic [WIDTH-1:0] rdData
);

  // Word-size code: one byte per word reads as 10h
  localparam logic [WIDTH-1:0] WORD_CODE = WIDTH'((WIDTH / 8) << 4);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] lastRead;
  logic [WIDTH-1:0] headByte;

  assign headByte = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)             lastRead <= '0;
    else if (strobe.pop) lastRead <= headByte;
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_DATA: rdData = fifoEmpty ? lastRead : headByte;
      SEL_CFGA: rdData = WORD_CODE;
      SEL_CFGB: rdData[WIDTH-2] = irqLevel;
      SEL_CTRL: rdData[0] = dirBit;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/ppTestFifo.sv
module ppTestFifo
  import ppFifoPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WIDTH     = 8,
  parameter int WR_THRESH = 4,
  parameter int RD_THRESH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             irqLevel,
  output logic [WIDTH-1:0] rdData,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic             serviceIntr
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  fifoStrobe_t      strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] occ;
  logic             dirBit;

  ppFifoCtrl #(
    .DEPTH(DEPTH), .WR_THRESH(WR_THRESH), .RD_THRESH(RD_THRESH),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .dirIn(wrData[0]), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .occ(occ), .dirBit(dirBit), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .serviceIntr(serviceIntr)
  );

  ppFifoData #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)
  ) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .regSel(regSel), .fifoEmpty(fifoEmpty),
    .dirBit(dirBit), .irqLevel(irqLevel), .rdData(rdData)
  );

endmodule

// File: rtl/ppTestFifoChk.sv
module ppTestFifoChk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       regSel,
  input logic             wrEn,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic             irqLevel,
  input logic             fifoFull,
  input logic             fifoEmpty,
  input logic [CNT_W-1:0] occ
);

  // R2: a write into a full FIFO leaves the occupancy alone
  a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (fifoFull && regSel == 2'b00 && wrEn && !rdEn) |=> (fifoFull && occ == $past(occ)));

  // R3: a read from an empty FIFO moves nothing
  a_r3_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
    (fifoEmpty && regSel == 2'b00 && rdEn && !wrEn) |=> fifoEmpty);

  // R4: the two flags never agree on 1, and the occupancy never exceeds the depth
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fifoFull && fifoEmpty));
  a_r4_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  // R8: the word-size register is fixed
  a_r8_cfga_value: assert property (@(posedge clk) disable iff (rst)
    (regSel == 2'b01) |-> (rdData == 8'h10));

  // R9: compression bit clear, irq line mirrored
  a_r9_cfgb_bits: assert property (@(posedge clk) disable iff (rst)
    (regSel == 2'b10) |-> (!rdData[7] && rdData[6] == irqLevel));

  // R11: a push and a pop in the same cycle keep the occupancy
  a_r11_push_pop_balance: assert property (@(posedge clk) disable iff (rst)
    (regSel == 2'b00 && wrEn && rdEn && !fifoFull && !fifoEmpty) |=> (occ == $past(occ)));

endmodule

bind ppTestFifo ppTestFifoChk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk (
  .clk(clk), .rst(rst), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .irqLevel(irqLevel), .fifoFull(fifoFull),
  .fifoEmpty(fifoEmpty), .occ(occ)
);

// File: tb/tb_ppTestFifo.sv
`timescale 1ns/1ps
module tb_ppTestFifo;

  localparam int DEPTH = 16;
  localparam int WR_TH = 4;
  localparam int RD_TH = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] regSel = 2'b00;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       irqLevel = 1'b0;
  logic [7:0] rdData;
  logic       fifoFull, fifoEmpty, serviceIntr;

  int tests = 0;
  int fails = 0;

  // Reference model
  logic [7:0] q[$];
  logic [7:0] lastRd = 8'h00;
  logic       dir = 1'b0;

  always #2.5 clk = ~clk;

  ppTestFifo dut (
    .clk(clk), .rst(rst), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .irqLevel(irqLevel), .rdData(rdData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .serviceIntr(serviceIntr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [1:0] s);
    case (s)
      2'b00:   return (q.size() == 0) ? lastRd : q[0];
      2'b01:   return 8'h10;
      2'b10:   return {1'b0, irqLevel, 6'b0};
      default: return {7'b0, dir};
    endcase
  endfunction

  task automatic checkFlags();
    logic expSvc;
    check("R4", {6'b0, fifoFull, fifoEmpty},
          {6'b0, q.size() == DEPTH, q.size() == 0});
    if (dir) begin
      expSvc = (q.size() >= RD_TH);
      check("R7", {7'b0, serviceIntr}, {7'b0, expSvc});
    end else begin
      expSvc = ((DEPTH - q.size()) >= WR_TH);
      check("R6", {7'b0, serviceIntr}, {7'b0, expSvc});
    end
  endtask

  // One bus cycle: drive at negedge, check read data, clock, update model, check flags
  task automatic doCycle(input logic [1:0] s, input logic w, input logic r,
                         input logic [7:0] d, input string req);
    bit popOk, pushOk;
    regSel = s; wrEn = w; rdEn = r; wrData = d;
    #1;
    check(req, rdData, modelRead(s));
    @(posedge clk);
    if (s == 2'b00) begin
      popOk  = r && (q.size() > 0);
      pushOk = w && (q.size() < DEPTH);
      if (popOk)  lastRd = q.pop_front();
      if (pushOk) q.push_back(d);
    end else if (s == 2'b11 && w) begin
      dir = d[0];
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    checkFlags();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checkFlags();
    doCycle(2'b00, 0, 0, 8'h00, "R1");
    doCycle(2'b11, 0, 0, 8'h00, "R1");

    // R5: order preserved
    doCycle(2'b00, 1, 0, 8'h44, "R5");
    doCycle(2'b00, 1, 0, 8'h33, "R5");
    doCycle(2'b00, 1, 0, 8'h22, "R5");
    for (int i = 0; i < 3; i++) doCycle(2'b00, 0, 1, 8'h00, "R5");

    // R3: reads past empty repeat the last byte
    doCycle(2'b00, 0, 1, 8'h00, "R3");
    doCycle(2'b00, 0, 1, 8'h00, "R3");

    // R2: fill, overfill, then drain and verify contents
    for (int i = 0; i < DEPTH; i++) doCycle(2'b00, 1, 0, 8'(i + 1), "R2");
    doCycle(2'b00, 1, 0, 8'hAA, "R2");
    doCycle(2'b00, 1, 0, 8'hBB, "R2");
    for (int i = 0; i < DEPTH; i++) doCycle(2'b00, 0, 1, 8'h00, "R2");
    doCycle(2'b00, 0, 1, 8'h00, "R3");

    // R10: direction bit via control register
    doCycle(2'b11, 1, 0, 8'hFF, "R10");
    doCycle(2'b11, 0, 0, 8'h00, "R10");

    // R7: direction 1, fill a byte at a time
    for (int i = 0; i < DEPTH; i++) doCycle(2'b00, 1, 0, 8'(8'hC0 + i), "R7");
    // R5: order independent of direction
    doCycle(2'b00, 0, 1, 8'h00, "R5");
    doCycle(2'b00, 0, 1, 8'h00, "R5");

    // R6: direction 0, drain a byte at a time
    doCycle(2'b11, 1, 0, 8'hFE, "R10");
    for (int i = 0; i < DEPTH; i++) doCycle(2'b00, 0, 1, 8'h00, "R6");

    // R8: fixed word-size code, writes ignored
    doCycle(2'b00, 1, 0, 8'h5A, "R8");
    doCycle(2'b01, 1, 0, 8'hFF, "R8");
    doCycle(2'b01, 0, 1, 8'h00, "R8");
    doCycle(2'b00, 0, 0, 8'h00, "R8");

    // R9: compression bit and irq mirror
    irqLevel = 1'b0;
    doCycle(2'b10, 0, 1, 8'h00, "R9");
    irqLevel = 1'b1;
    doCycle(2'b10, 0, 0, 8'h00, "R9");
    doCycle(2'b10, 1, 0, 8'hFF, "R9");

    // R11: simultaneous read and write
    doCycle(2'b00, 1, 1, 8'h61, "R11");
    doCycle(2'b00, 1, 1, 8'h62, "R11");
    doCycle(2'b00, 0, 1, 8'h00, "R11");
    doCycle(2'b00, 1, 1, 8'h63, "R11");
    for (int i = 0; i < DEPTH; i++) doCycle(2'b00, 1, 0, 8'(8'h70 + i), "R11");
    doCycle(2'b00, 1, 1, 8'h99, "R11");
    for (int i = 0; i < DEPTH; i++) doCycle(2'b00, 0, 1, 8'h00, "R11");
    doCycle(2'b00, 0, 1, 8'h00, "R3");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule